// File: doc/BRIEF.md
# Output-Gated Low-Power Scan Chain

This block is a parameterized chain of scan flip-flops that sits between the functional flops of a design under test and the combinational logic they drive. Each cell has one storage flop and a two-input selector. A shared scan-enable picks what the flop loads: the cell's functional data input (capture) or the stored bit of its neighbour (shift).

Each cell has two outputs. The functional output drives the downstream logic. A separate scan output carries the stored bit to the next cell. While scan-enable is high, every functional output is held at 0. Test data moving through the chain therefore never toggles the logic under the flops, which saves switching power during long shift sequences. When scan-enable drops, the functional outputs show the stored values again without waiting for a clock. The scan outputs are never gated, so shifting works while the functional side stays quiet.

Data enters at the top cell (index N-1) and leaves from cell 0, which drives the serial output. After a parallel capture, a shift unload therefore presents the cells lowest index first and the most significant cell last.

Top module: `lp_scan_chain`

## Requirements
- R1: When scan_en is 0 and rst_n is 1, a rising clock edge loads func_d[k] into cell k for every k in parallel.
- R2: When scan_en is 1 and rst_n is 1, a rising clock edge loads scan_in into cell N-1 and the old value of cell k+1 into cell k, for k from 0 to N-2.
- R3: Whenever scan_en is 1, every bit of func_q is 0.
- R4: Whenever scan_en is 0, func_q[k] equals the stored bit of cell k. This holds combinationally in the same cycle that scan_en falls, with no clock edge needed.
- R5: When rst_n is 0 at a rising edge, every stored bit clears to 0, whatever scan_en is.
- R6: After a capture of value D, the j-th subsequent shift edge leaves D[j] on scan_out, so D[0] appears first and D[N-1] appears last.
- R7: A bit applied on scan_in at the first of a run of shift edges appears on scan_out after exactly N shift edges. For N=8, the fixed patterns 0x55, 0xAA, 0xFF and 0x00, fed bit 0 first, come out unchanged in the same bit order.
- R8: scan_out always equals the stored bit of cell 0, whatever the value of scan_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | 1 = shift and gate the functional outputs; 0 = capture |
| scan_in | input | 1 | Serial data into cell N-1 |
| func_d | input | N | Functional data input of each cell |
| func_q | output | N | Gated functional outputs, 0 while scan_en is 1 |
| scan_out | output | 1 | Stored bit of cell 0 |

## Verification
The bench builds the chain with N=8. At that length the four fixed byte patterns fill the chain exactly, so each pattern's round trip through scan_in and scan_out takes one full load and one full unload. Eight cells also keep every single-bit position within reach of the random mix of capture, shift and reset cycles. The test checks the gating of the functional outputs in every cycle in which scan_en is high. It also checks their return to the stored values at the moment scan_en drops, before the next clock edge.

// File: rtl/lp_scan_pkg.sv
// Package lp_scan_pkg
// Purpose : shared mode type for the output-gated scan chain.
// Assumes : scan enable is a single active-high control bit.
package lp_scan_pkg;

    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_SHIFT   = 1'b1
    } scan_mode_e;

    // Map the raw scan-enable pin onto the mode type.
    function automatic scan_mode_e mode_of(input logic se);
        return se ? MODE_SHIFT : MODE_CAPTURE;
    endfunction

endpackage

// File: rtl/lp_func_gate.sv
// Module lp_func_gate
// Purpose : forces a functional output to 0 while the chain is in shift mode,
//           so shifted test data does not reach downstream logic.
// Assumes : purely combinational; the value it passes is a flop output.
module lp_func_gate (
    input  logic scan_en,
    input  logic stored,
    output logic gated
);

    // Pass the stored bit only in capture mode.
    always_comb begin
        gated = stored & ~scan_en;
    end

endmodule

// File: rtl/lp_scan_cell.sv
// Module lp_scan_cell
// Purpose : one scan flop. It has a capture/shift selector, a gated functional
//           output and an ungated scan output for the next cell.
// Assumes : synchronous active-low reset; scan_en is shared by the whole chain.
module lp_scan_cell
    import lp_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    input  logic d,
    input  logic si,
    output logic q,
    output logic so
);

    logic       stored_r;
    logic       next_bit;
    scan_mode_e mode;

    // Decode the mode and select the flop's next value.
    always_comb begin
        mode = mode_of(scan_en);
        unique case (mode)
            MODE_SHIFT:   next_bit = si;
            MODE_CAPTURE: next_bit = d;
            default:      next_bit = d;
        endcase
    end

    // Storage flop with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stored_r <= 1'b0;
        else        stored_r <= next_bit;
    end

    assign so = stored_r;

    lp_func_gate u_gate (
        .scan_en (scan_en),
        .stored  (stored_r),
        .gated   (q)
    );

    AST_CELL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> so == $past(d)); // R1
    AST_CELL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> so == $past(si)); // R2
    AST_CELL_RESET: assert property (@(posedge clk)
        !rst_n |=> so == 1'b0); // R5

endmodule

// File: rtl/lp_scan_chain.sv
// Module lp_scan_chain (top)
// Purpose : N output-gated scan cells. scan_in enters cell N-1, each cell k
//           feeds cell k-1, and cell 0 drives scan_out.
// Assumes : N >= 2; all cells share clk, rst_n and scan_en.
module lp_scan_chain #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scan_en,
    input  logic         scan_in,
    input  logic [N-1:0] func_d,
    output logic [N-1:0] func_q,
    output logic         scan_out
);

    localparam int LAST = N - 1;

    logic [N-1:0] link_so;
    logic [N-1:0] link_si;

    // Route each cell's serial input from its upper neighbour or the pin.
    always_comb begin
        link_si[LAST] = scan_in;
        for (int k = 0; k < LAST; k++) begin
            link_si[k] = link_so[k+1];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cell
        lp_scan_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .scan_en (scan_en),
            .d       (func_d[g]),
            .si      (link_si[g]),
            .q       (func_q[g]),
            .so      (link_so[g])
        );
    end

    assign scan_out = link_so[0];

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> func_q == '0); // R3
    AST_FUNC_MATCHES_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> func_q == link_so); // R4
    AST_SERIAL_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scan_en) && $past(rst_n) |-> scan_out == $past(link_so[1])); // R8

endmodule

// File: tb/lp_scan_chain_tb.sv
`timescale 1ns/1ps
module lp_scan_chain_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] func_d = '0;
    logic [N-1:0] func_q;
    logic         scan_out;

    logic [N-1:0] model = '0;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lp_scan_chain #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
        .func_d(func_d), .func_q(func_q), .scan_out(scan_out)
    );

    function automatic logic [N-1:0] next_state(input logic [N-1:0] cur,
            input logic r, input logic se, input logic si, input logic [N-1:0] d);
        if (!r)      return '0;
        else if (se) return {si, cur[N-1:1]};
        else         return d;
    endfunction

    function automatic logic [N-1:0] expect_func(input logic [N-1:0] cur, input logic se);
        return se ? '0 : cur;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply inputs at the falling edge, check outputs, then model the rising edge.
    task automatic drive(input logic r, input logic se, input logic si, input logic [N-1:0] d);
        @(negedge clk);
        rst_n = r; scan_en = se; scan_in = si; func_d = d;
        #1;
        chk(se ? "R3" : "R4", func_q, expect_func(model, se));
        chk("R8", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, model[0]});
        @(posedge clk);
        model = next_state(model, r, se, si, d);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pats [4];
        void'($urandom(32'h5CA1));
        pats[0] = 8'h55; pats[1] = 8'hAA; pats[2] = 8'hFF; pats[3] = 8'h00;

        // Reset state (R5)
        drive(0, 0, 0, '0);
        drive(0, 1, 1, '1);
        #1;
        chk("R5", func_q, '0);
        chk("R5", {{(N-1){1'b0}}, scan_out}, '0);

        // Parallel capture then serial unload, lowest cell first (R1, R6)
        drive(1, 0, 0, 8'hA5);
        #1;
        chk("R1", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, 1'b1});
        for (int j = 1; j < N; j++) begin
            drive(1, 1, 0, '0);
            #1;
            chk("R6", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, model[0]});
            chk("R6", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, 8'hA5 >> j} & 1);
        end

        // Fixed patterns through the whole chain (R7, R2)
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < N; i++) drive(1, 1, pats[p][i], '0);
            for (int i = 0; i < N; i++) begin
                #1;
                chk("R7", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, pats[p][i]});
                drive(1, 1, 0, '0);
            end
        end

        // Gating released combinationally when scan_en drops (R4, R3)
        drive(1, 0, 0, 8'h3C);
        drive(1, 1, 1, 8'h00);
        drive(1, 0, 0, 8'hC3);
        #1;
        chk("R1", func_q, 8'hC3);

        // Reset in the middle of a shift (R5)
        drive(1, 0, 0, 8'hFF);
        drive(0, 1, 1, 8'hFF);
        #1;
        chk("R5", {{(N-1){1'b0}}, scan_out}, '0);

        // Constrained random mix (R2, R3, R4, R8)
        for (int c = 0; c < 400; c++) begin
            logic r;
            r = ($urandom_range(49) != 0);
            drive(r, 1'($urandom_range(1)), 1'($urandom_range(1)), N'($urandom));
            #1;
            chk("R2", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, model[0]});
        end

        drive(1, 0, 0, '0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule